// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block is the address front end of a synchronous burst cache memory. It takes a word address and registers it when one of two address strobes is asserted. One strobe comes from the processor and the other from the cache controller. For the rest of a four-beat burst it then supplies the current word address on its own. Only the two low address bits step. They advance on clock edges where the advance input is asserted, and they wrap so that a burst covers exactly four words.

A static order input selects the stepping order. In interleaved order the low bits are the start bits XOR the beat count. In linear order they are the start bits plus the beat count, modulo four. The block also reports the beat count and whether a burst is active. The processor strobe is qualified by a chip-enable value registered on the previous edge. The controller strobe always loads, and it takes the current chip enable as the selection of the new burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, addr_o is 0, beat_o is 0 and active_o is 0.
- R2: A rising edge with ctl_stb_i high and no accepted processor strobe loads addr_i. From the next cycle addr_o equals that address and beat_o is 0. active_o takes the value ce_i had on that edge.
- R3: cpu_stb_i is accepted only if ce_i was high on the previous rising edge. An accepted strobe loads addr_i, clears beat_o and sets active_o to 1. A strobe that is not accepted has no effect, and an advance on that edge proceeds as if no strobe were present.
- R4: If both strobes are high on the same edge and the processor strobe is accepted, the processor load wins: active_o becomes 1 even when ce_i is low.
- R5: On an edge with adv_i high, active_o high and no accepted strobe, beat_o increments by one and wraps from 3 to 0.
- R6: With adv_i low and no strobe accepted, beat_o and addr_o keep their values, for any number of cycles.
- R7: While active_o is low, adv_i has no effect on beat_o or addr_o.
- R8: With order_i = 1 (interleaved), addr_o[1:0] equals the captured start bits XOR beat_o.
- R9: With order_i = 0 (linear), addr_o[1:0] equals the captured start bits plus beat_o, modulo 4.
- R10: addr_o[16:2] stays equal to the captured address bits 16..2 until the next accepted strobe.
- R11: An accepted strobe takes priority over adv_i on the same edge, so the beat restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Word address sampled on a strobe |
| cpu_stb_i | input | 1 | Processor address strobe |
| ctl_stb_i | input | 1 | Cache controller address strobe |
| adv_i | input | 1 | Advance request for the burst counter |
| ce_i | input | 1 | Chip enable, sampled every edge |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_o | output | 17 | Current word address of the burst |
| beat_o | output | 2 | Beat count within the burst |
| active_o | output | 1 | A selected burst is in progress |

## Verification
The assertions assume that strobes, advance and chip enable are stable around the rising edge. They also assume the order input does not change while a burst is being checked, because the low address bits are formed from it without a register. The stimulus drives every input on the falling edge and samples outputs just after the rising edge. It sets the order once for each directed and random segment and never changes it in the middle of one. Chip enable is driven low only in short windows, so that both accepted and ignored processor strobes occur.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } load_src_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_addr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cpu_stb_i,
  input  logic      ctl_stb_i,
  input  logic      ce_i,
  output load_src_e src_o
);
  logic ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b0;
    else         ce_q <= ce_i;
  end

  // processor strobe qualified by last edge's chip enable; it wins a tie
  always_comb begin
    if (cpu_stb_i && ce_q) src_o = SRC_CPU;
    else if (ctl_stb_i)    src_o = SRC_CTL;
    else                   src_o = SRC_NONE;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] beat_o
);
  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + 1'b1;  // natural wrap
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_addr_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  order_e           order_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] beat_i,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] lin_w;
  logic [CNT_W-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_w : lin_w;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_stb_i,
  input  logic              ctl_stb_i,
  input  logic              adv_i,
  input  logic              ce_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  beat_o,
  output logic              active_o
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  load_src_e        src_w;
  logic             load_w;
  logic             step_w;
  logic [ADDR_W-1:0] base_q;
  logic             active_q;
  logic [CNT_W-1:0] beat_w;
  logic [CNT_W-1:0] low_w;
  order_e           order_w;

  burst_strobe_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpu_stb_i(cpu_stb_i),
    .ctl_stb_i(ctl_stb_i),
    .ce_i     (ce_i),
    .src_o    (src_w)
  );

  assign load_w = (src_w != SRC_NONE);
  assign step_w = adv_i && active_q && !load_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      active_q <= 1'b0;
    end else if (load_w) begin
      base_q   <= addr_i;
      active_q <= (src_w == SRC_CPU) ? 1'b1 : ce_i;
    end
  end

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load_w),
    .step_i (step_w),
    .beat_o (beat_w)
  );

  assign order_w = order_e'(order_i);

  burst_seq_map #(.CNT_W(CNT_W)) u_map (
    .order_i(order_w),
    .start_i(base_q[CNT_W-1:0]),
    .beat_i (beat_w),
    .low_o  (low_w)
  );

  assign addr_o   = {base_q[ADDR_W-1 -: HI_W], low_w};
  assign beat_o   = beat_w;
  assign active_o = active_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cpu_stb_i,
  input logic              ctl_stb_i,
  input logic              adv_i,
  input logic              ce_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  beat_o,
  input logic              active_o
);
  logic ce_prev;
  logic cpu_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_prev <= 1'b0;
    else         ce_prev <= ce_i;
  end

  assign cpu_ok = cpu_stb_i && ce_prev;

  assert_ctl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_stb_i && !cpu_ok) |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_i[ADDR_W-1:CNT_W])
                                && beat_o == '0 && active_o == $past(ce_i)));

  assert_cpu_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ok |=> (beat_o == '0 && active_o));

  assert_cpu_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ok && ctl_stb_i && !ce_i) |=> active_o);

  assert_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && active_o && !cpu_ok && !ctl_stb_i) |=> beat_o == CNT_W'($past(beat_o) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !cpu_ok && !ctl_stb_i) |=> $stable(beat_o));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !cpu_ok && !ctl_stb_i) |=> (!active_o && $stable(beat_o)));

  assert_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_ok && !ctl_stb_i) |=> $stable(addr_o[ADDR_W-1:CNT_W]));

  assert_strobe_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (cpu_ok || ctl_stb_i)) |=> beat_o == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .cpu_stb_i(cpu_stb_i),
  .ctl_stb_i(ctl_stb_i),
  .adv_i    (adv_i),
  .ce_i     (ce_i),
  .addr_o   (addr_o),
  .beat_o   (beat_o),
  .active_o (active_o)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cpu_stb = 1'b0, ctl_stb = 1'b0, adv = 1'b0, ce = 1'b0, order = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          active_o;

  int checks = 0, errors = 0, cycles = 0;

  // reference state
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act  = 1'b0;
  logic          m_ceq  = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .cpu_stb_i(cpu_stb),
    .ctl_stb_i(ctl_stb), .adv_i(adv), .ce_i(ce), .order_i(order),
    .addr_o(addr_o), .beat_o(beat_o), .active_o(active_o)
  );

  function automatic logic [1:0] exp_low(input logic ord, input logic [1:0] s, input logic [1:0] b);
    return ord ? (s ^ b) : 2'(s + b);
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic ord);
    return {m_base[AW-1:2], exp_low(ord, m_base[1:0], m_beat)};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    ea = exp_addr(order);
    checks++;
    if (addr_o !== ea || beat_o !== m_beat || active_o !== m_act) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d act=%0b, expected addr=%h beat=%0d act=%0b",
               tag, addr_o, beat_o, active_o, ea, m_beat, m_act);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic c, input logic p,
                      input logic v, input logic e, input string tag);
    @(negedge clk);
    addr_i = a; ctl_stb = c; cpu_stb = p; adv = v; ce = e;
    @(posedge clk);
    if (p && m_ceq) begin
      m_base = a; m_beat = 2'd0; m_act = 1'b1;
    end else if (c) begin
      m_base = a; m_beat = 2'd0; m_act = e;
    end else if (v && m_act) begin
      m_beat = m_beat + 2'd1;
    end
    m_ceq = e;
    #1;
    check(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: cycles=%0d, expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release");

    // R8 / R9 every start value, both orders, with held-off advances (R5, R6, R10)
    for (int o = 0; o < 2; o++) begin
      order = o[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {15'(17'h1A5C3 >> (2 + s)), s[1:0]};
        step(a, 1'b1, 1'b0, 1'b0, 1'b1, "R2 ctl load");
        for (int k = 0; k < 5; k++) begin
          step(a ^ 17'h1FFFC, 1'b0, 1'b0, 1'b1, 1'b1, o ? "R8 interleave R5" : "R9 linear R5");
          for (int h = 0; h < (k % 3); h++)
            step('0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 hold R10");
        end
      end
    end

    // R2 controller load with ce low, then R7 advance ignored
    order = 1'b0;
    step(17'h0ABCD, 1'b1, 1'b0, 1'b0, 1'b0, "R2 ctl load deselected");
    step(17'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R7 adv while idle");
    step(17'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R7 adv while idle");
    // R3 processor strobe rejected (ce was low at previous edge)
    step(17'h13333, 1'b0, 1'b1, 1'b0, 1'b1, "R3 cpu ignored");
    // R3 accepted now (ce high last edge)
    step(17'h12346, 1'b0, 1'b1, 1'b0, 1'b1, "R3 cpu accepted");
    step(17'h00000, 1'b0, 1'b0, 1'b1, 1'b0, "R5 advance");
    // ce was low last edge: cpu strobe ignored, advance proceeds
    step(17'h1FFFF, 1'b0, 1'b1, 1'b1, 1'b1, "R3 ignored strobe lets advance");
    // R4 both strobes, cpu accepted, ce low now
    step(17'h05551, 1'b1, 1'b1, 1'b0, 1'b0, "R4 cpu wins tie");
    step(17'h00000, 1'b0, 1'b0, 1'b1, 1'b1, "R5 advance");
    // R11 strobe plus advance
    step(17'h0F0F3, 1'b1, 1'b0, 1'b1, 1'b1, "R11 strobe beats advance");
    for (int k = 0; k < 5; k++) step('0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 wrap");

    // constrained random segments
    for (int seg = 0; seg < 8; seg++) begin
      order = seg[0];
      for (int n = 0; n < 400; n++) begin
        logic [AW-1:0] a;
        logic c, p, v, e;
        a = AW'($urandom);
        c = ($urandom % 7) == 0;
        p = ($urandom % 6) == 0;
        v = ($urandom % 3) != 0;
        e = ($urandom % 8) != 0;
        step(a, c, p, v, e, order ? "R8 random" : "R9 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule